// File: doc/BRIEF.md
# Ring-Oscillator Aging Sensor Controller

This block drives a two-oscillator wear sensor that tells a fresh chip from one that has already spent time in service. One ring oscillator, the reference, is kept asleep for the whole life of the part. The other, the stressed oscillator, sits under DC stress whenever the chip runs normally. Over time its threshold voltage drifts and it slows down. A two-bit mode input selects the operating condition. The controller turns that mode into the sleep, run-hold and stress-select lines of both oscillators. It also keeps the run-hold and stress-select lines from ever being active together, because that combination would short the stressed ring.

When an authentication mode is selected, the controller runs one timed measurement. First it wakes the reference oscillator alone for a fixed window of system-clock cycles, then waits a settle interval. Then it wakes the stressed oscillator alone for the same window and waits the same settle interval. Each oscillator drives its own free-running counter, kept in Gray code. The system clock reads that counter through a two-flop synchronizer, before and after each window. When the sequence ends, the block presents both counts, their signed difference, and an aged flag. The flag is set when the difference exceeds a threshold given as an input.

The result leaves on a valid/ready interface. `res_valid` rises once and stays up, with all result fields frozen, until `res_ready` is seen high on a clock edge. After that handshake the oscillators stay asleep. No further measurement starts until the mode leaves authentication and comes back. Moving away from authentication at any point aborts the sequence.

Top module: `ro_age_ctrl`

## Requirements
- R1: After reset, the block sits in the burn-in control state: `ref_wake`=0, `str_wake`=0, `ring_hold`=1, `str_stress`=0, `res_valid`=0, and both counts are 0.
- R2: Mode 2'b00 (manufacturing/burn-in) gives `ref_wake`=0, `str_wake`=0, `ring_hold`=1 and `str_stress`=0 from the cycle after the mode is seen. This holds for as long as the mode stays 2'b00.
- R3: Mode 2'b01 (normal use) gives `ref_wake`=0, `str_wake`=1, `str_stress`=1 and `ring_hold`=0 from the cycle after the mode is seen. This keeps the reference asleep and the stressed ring under DC stress.
- R4: `ring_hold` and `str_stress` are never 1 in the same cycle, in any state or across any transition.
- R5: In authentication, `ref_wake` is 1 (with `str_wake`=0 and `ring_hold`=0) for exactly WINDOW cycles. Only after that is `str_wake` 1 with `str_stress`=0 for exactly WINDOW cycles. The two wake lines are never 1 together.
- R6: `ref_count` and `stress_count` each equal, within one, the number of rising edges their oscillator input showed while its own measurement window was open.
- R7: `diff` is the signed value `ref_count - stress_count`, and `aged` is 1 exactly when `diff` is greater than the unsigned `threshold`.
- R8: Once `res_valid` rises, it and every result field stay unchanged until a clock edge with `res_ready`=1. After that edge, `res_valid` is 0 and both wake lines stay 0 while the mode stays in authentication.
- R9: If the mode leaves authentication while the sequence is running, the next cycle shows the new mode's control values, `res_valid`=0, and both counts 0.
- R10: Both 2'b10 and 2'b11 select authentication and give the same measurement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode | input | 2 | Operating mode: 00 burn-in, 01 normal, 1x authentication |
| ref_osc | input | 1 | Reference ring oscillator output |
| str_osc | input | 1 | Stressed ring oscillator output |
| threshold | input | CW | Aged-decision threshold on the count difference |
| ref_wake | output | 1 | Reference ring powered (0 = asleep) |
| str_wake | output | 1 | Stressed ring powered (0 = asleep) |
| ring_hold | output | 1 | Common run-hold; 0 lets powered rings oscillate |
| str_stress | output | 1 | Stressed ring DC-stress select; 0 lets it oscillate |
| ref_count | output | CW | Reference edge count over the window |
| stress_count | output | CW | Stressed edge count over the window |
| diff | output | CW+1 | Signed ref_count minus stress_count |
| aged | output | 1 | diff exceeds threshold |
| res_valid | output | 1 | Result fields valid |
| res_ready | input | 1 | Consumer accepts the result |

## Verification
The bench goes after the measurement order. It counts cycles of each wake line and flags any stressed-window cycle that comes before a reference-window cycle. A design that woke both rings at once, or measured in the wrong order, would show overlapping or reversed windows. It also aborts the sequence once in each window and checks that the new mode's controls and cleared counts appear on the very next cycle. A design that finished the current step first would leave a stale wake line up or still report a result. It stalls the result with `res_ready` low to catch fields that drift or a valid that drops on its own. It runs the comparison with thresholds on both sides of the measured difference, where an unsigned or off-by-one compare would flip `aged`.

// File: rtl/ro_age_pkg.sv
package ro_age_pkg;

  typedef enum logic [2:0] {
    ST_BURN,   // both rings asleep
    ST_NORM,   // stressed ring under DC stress
    ST_MREF,   // reference window open
    ST_SREF,   // reference settle
    ST_MSTR,   // stressed window open
    ST_SSTR,   // stressed settle
    ST_DONE,   // result offered
    ST_PARK    // result taken, idle in authentication
  } seq_st_t;

  function automatic logic [63:0] to_gray(input logic [63:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [63:0] from_gray(input logic [63:0] g, input int unsigned w);
    logic [63:0] b;
    b = '0;
    for (int i = 63; i >= 0; i--) begin
      if (i < int'(w)) b[i] = g[i] ^ ((i == int'(w) - 1) ? 1'b0 : b[i+1]);
    end
    return b;
  endfunction

endpackage

// File: rtl/ro_edge_counter.sv
module ro_edge_counter #(
  parameter int CW = 16
) (
  input  logic          osc,
  input  logic          rst_n,
  output logic [CW-1:0] gray_cnt
);
  import ro_age_pkg::*;

  logic [CW-1:0] bin_cnt;
  logic [CW-1:0] bin_nxt;
  logic [63:0]   g_wide;

  assign bin_nxt = bin_cnt + CW'(1);
  assign g_wide  = to_gray(64'(bin_nxt));

  always_ff @(posedge osc or negedge rst_n) begin
    if (!rst_n) begin
      bin_cnt  <= '0;
      gray_cnt <= '0;
    end else begin
      bin_cnt  <= bin_nxt;
      gray_cnt <= g_wide[CW-1:0];
    end
  end
endmodule

// File: rtl/gray_sync.sv
module gray_sync #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] gray_in,
  output logic [CW-1:0] bin_out
);
  import ro_age_pkg::*;

  logic [CW-1:0] meta_q;
  logic [CW-1:0] sync_q;
  logic [63:0]   b_wide;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= gray_in;
      sync_q <= meta_q;
    end
  end

  assign b_wide  = from_gray(64'(sync_q), CW);
  assign bin_out = b_wide[CW-1:0];
endmodule

// File: rtl/ro_age_seq.sv
module ro_age_seq #(
  parameter int CW     = 16,
  parameter int WINDOW = 200,
  parameter int SETTLE = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    mode,
  input  logic [CW-1:0] ref_now,
  input  logic [CW-1:0] str_now,
  input  logic          res_ready,
  output logic          ref_wake,
  output logic          str_wake,
  output logic          ring_hold,
  output logic          str_stress,
  output logic [CW-1:0] ref_count,
  output logic [CW-1:0] stress_count,
  output logic          res_valid
);
  import ro_age_pkg::*;

  localparam int TMAX = (WINDOW > SETTLE) ? WINDOW : SETTLE;
  localparam int TW   = $clog2(TMAX + 1);
  localparam logic [TW-1:0] WIN_END = TW'(WINDOW - 1);
  localparam logic [TW-1:0] SET_END = TW'(SETTLE - 1);

  seq_st_t       st;
  logic [TW-1:0] tmr;
  logic [CW-1:0] base;
  logic          auth;

  assign auth = mode[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st           <= ST_BURN;
      tmr          <= '0;
      base         <= '0;
      ref_count    <= '0;
      stress_count <= '0;
      res_valid    <= 1'b0;
    end else if (!auth) begin
      st           <= mode[0] ? ST_NORM : ST_BURN;
      tmr          <= '0;
      ref_count    <= '0;
      stress_count <= '0;
      res_valid    <= 1'b0;
    end else begin
      unique case (st)
        ST_BURN, ST_NORM: begin
          st   <= ST_MREF;
          tmr  <= '0;
          base <= ref_now;
        end
        ST_MREF: begin
          if (tmr == WIN_END) begin st <= ST_SREF; tmr <= '0; end
          else tmr <= tmr + TW'(1);
        end
        ST_SREF: begin
          if (tmr == SET_END) begin
            st        <= ST_MSTR;
            tmr       <= '0;
            ref_count <= ref_now - base;
            base      <= str_now;
          end else tmr <= tmr + TW'(1);
        end
        ST_MSTR: begin
          if (tmr == WIN_END) begin st <= ST_SSTR; tmr <= '0; end
          else tmr <= tmr + TW'(1);
        end
        ST_SSTR: begin
          if (tmr == SET_END) begin
            st           <= ST_DONE;
            tmr          <= '0;
            stress_count <= str_now - base;
            res_valid    <= 1'b1;
          end else tmr <= tmr + TW'(1);
        end
        ST_DONE: begin
          if (res_ready) begin st <= ST_PARK; res_valid <= 1'b0; end
        end
        default: st <= ST_PARK;
      endcase
    end
  end

  // control decode: hold and stress are driven from disjoint state sets
  always_comb begin
    ref_wake   = 1'b0;
    str_wake   = 1'b0;
    ring_hold  = 1'b1;
    str_stress = 1'b0;
    unique case (st)
      ST_NORM: begin str_wake = 1'b1; str_stress = 1'b1; ring_hold = 1'b0; end
      ST_MREF: begin ref_wake = 1'b1; ring_hold = 1'b0; end
      ST_MSTR: begin str_wake = 1'b1; ring_hold = 1'b0; end
      default: ;
    endcase
  end
endmodule

// File: rtl/ro_age_ctrl.sv
module ro_age_ctrl #(
  parameter int CW     = 16,
  parameter int WINDOW = 200,
  parameter int SETTLE = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    mode,
  input  logic          ref_osc,
  input  logic          str_osc,
  input  logic [CW-1:0] threshold,
  output logic          ref_wake,
  output logic          str_wake,
  output logic          ring_hold,
  output logic          str_stress,
  output logic [CW-1:0] ref_count,
  output logic [CW-1:0] stress_count,
  output logic [CW:0]   diff,
  output logic          aged,
  output logic          res_valid,
  input  logic          res_ready
);
  localparam int NLANE = 2;

  logic [NLANE-1:0] osc_bus;
  logic [CW-1:0]    lane_gray [NLANE];
  logic [CW-1:0]    lane_bin  [NLANE];

  assign osc_bus = {str_osc, ref_osc};

  for (genvar i = 0; i < NLANE; i++) begin : g_lane
    ro_edge_counter #(.CW(CW)) u_cnt (
      .osc      (osc_bus[i]),
      .rst_n    (rst_n),
      .gray_cnt (lane_gray[i])
    );
    gray_sync #(.CW(CW)) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .gray_in (lane_gray[i]),
      .bin_out (lane_bin[i])
    );
  end

  ro_age_seq #(.CW(CW), .WINDOW(WINDOW), .SETTLE(SETTLE)) u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .mode         (mode),
    .ref_now      (lane_bin[0]),
    .str_now      (lane_bin[1]),
    .res_ready    (res_ready),
    .ref_wake     (ref_wake),
    .str_wake     (str_wake),
    .ring_hold    (ring_hold),
    .str_stress   (str_stress),
    .ref_count    (ref_count),
    .stress_count (stress_count),
    .res_valid    (res_valid)
  );

  assign diff = $signed({1'b0, ref_count}) - $signed({1'b0, stress_count});
  assign aged = $signed(diff) > $signed({1'b0, threshold});
endmodule

// File: rtl/ro_age_checker.sv
module ro_age_checker #(
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic [1:0]    mode,
  input logic          ref_wake,
  input logic          str_wake,
  input logic          ring_hold,
  input logic          str_stress,
  input logic [CW-1:0] ref_count,
  input logic [CW-1:0] stress_count,
  input logic          res_valid,
  input logic          res_ready
);
  p_interlock_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(ring_hold && str_stress));

  p_burn_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b00) |=> (!ref_wake && !str_wake && ring_hold && !str_stress));

  p_normal_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b01) |=> (!ref_wake && str_wake && str_stress && !ring_hold));

  p_one_ring_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(ref_wake && str_wake));

  p_result_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=>
      (res_valid && $stable(ref_count) && $stable(stress_count)));

  p_abort_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mode[1] == 1'b0) |=> (!res_valid && ref_count == '0 && stress_count == '0));
endmodule

bind ro_age_ctrl ro_age_checker #(.CW(CW)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .mode         (mode),
  .ref_wake     (ref_wake),
  .str_wake     (str_wake),
  .ring_hold    (ring_hold),
  .str_stress   (str_stress),
  .ref_count    (ref_count),
  .stress_count (stress_count),
  .res_valid    (res_valid),
  .res_ready    (res_ready)
);

// File: tb/ro_age_ctrl_test.sv
`timescale 1ns/1ps
module ro_age_ctrl_test;
  localparam int CW     = 16;
  localparam int WINDOW = 200;
  localparam int SETTLE = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [1:0]    mode = 2'b00;
  logic [CW-1:0] threshold = '0;
  logic          res_ready = 1'b0;
  logic          ref_raw = 1'b0, str_raw = 1'b0;
  logic          ref_osc, str_osc;
  logic          ref_wake, str_wake, ring_hold, str_stress, aged, res_valid;
  logic [CW-1:0] ref_count, stress_count;
  logic [CW:0]   diff;
  int            checks = 0, fails = 0;
  bit            lock_bad = 1'b0;

  always #10 clk = ~clk;     // 50 MHz
  always #8  ref_raw = ~ref_raw;   // 16 ns period
  always #9  str_raw = ~str_raw;   // 18 ns period

  // oscillator model: runs only when powered and released
  assign ref_osc = ref_raw & ref_wake & ~ring_hold;
  assign str_osc = str_raw & str_wake & ~ring_hold & ~str_stress;

  ro_age_ctrl #(.CW(CW), .WINDOW(WINDOW), .SETTLE(SETTLE)) uut (
    .clk(clk), .rst_n(rst_n), .mode(mode), .ref_osc(ref_osc), .str_osc(str_osc),
    .threshold(threshold), .ref_wake(ref_wake), .str_wake(str_wake),
    .ring_hold(ring_hold), .str_stress(str_stress), .ref_count(ref_count),
    .stress_count(stress_count), .diff(diff), .aged(aged),
    .res_valid(res_valid), .res_ready(res_ready)
  );

  always @(negedge clk) if (rst_n && ring_hold && str_stress) lock_bad = 1'b1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk(ref_wake == 0 && str_wake == 0 && ring_hold == 1 && str_stress == 0, "R1 controls",
        {ref_wake, str_wake, ring_hold, str_stress}, 4'b0010);
    chk(res_valid == 0 && ref_count == 0 && stress_count == 0, "R1 results",
        ref_count + stress_count + res_valid, 0);
  endtask

  task automatic t_burn;
    mode = 2'b00;
    repeat (5) @(negedge clk);
    chk({ref_wake, str_wake, ring_hold, str_stress} == 4'b0010, "R2 burn-in controls",
        {ref_wake, str_wake, ring_hold, str_stress}, 4'b0010);
  endtask

  task automatic t_normal;
    @(negedge clk); mode = 2'b01;
    @(negedge clk);
    chk({ref_wake, str_wake, ring_hold, str_stress} == 4'b0101, "R3 normal controls",
        {ref_wake, str_wake, ring_hold, str_stress}, 4'b0101);
    repeat (20) @(negedge clk);
    chk({ref_wake, str_wake, ring_hold, str_stress} == 4'b0101, "R3 normal held",
        {ref_wake, str_wake, ring_hold, str_stress}, 4'b0101);
  endtask

  task automatic t_auth(input logic [1:0] m, input int thr);
    int nref = 0, nstr = 0, order_bad = 0, both = 0;
    bit seen_str = 0;
    int r, s, d;
    @(negedge clk);
    threshold = CW'(thr); res_ready = 1'b0; mode = m;
    for (int k = 0; k < 3000 && !res_valid; k++) begin
      @(negedge clk);
      if (ref_wake && str_wake) both++;
      if (ref_wake) begin nref++; if (seen_str) order_bad++; end
      if (str_wake) begin nstr++; seen_str = 1; end
    end
    chk(res_valid, "R10 result arrives", res_valid, 1);
    chk(nref == WINDOW, "R5 reference window", nref, WINDOW);
    chk(nstr == WINDOW, "R5 stressed window", nstr, WINDOW);
    chk(order_bad == 0 && both == 0, "R5 order", order_bad + both, 0);
    r = int'(ref_count); s = int'(stress_count);
    chk(r >= 249 && r <= 251, "R6 ref count", r, 250);
    chk(s >= 221 && s <= 223, "R6 stressed count", s, 222);
    d = int'($signed(diff));
    chk(d == r - s, "R7 diff", d, r - s);
    chk(aged == (d > thr), "R7 aged", aged, int'(d > thr));
    repeat (3) @(negedge clk);
    chk(res_valid && int'(ref_count) == r && int'(stress_count) == s, "R8 hold under stall",
        int'(ref_count), r);
    res_ready = 1'b1;
    @(negedge clk);
    res_ready = 1'b0;
    chk(!res_valid, "R8 accepted", res_valid, 0);
    nref = 0;
    repeat (50) begin @(negedge clk); if (ref_wake || str_wake || res_valid) nref++; end
    chk(nref == 0, "R8 parked", nref, 0);
    mode = 2'b00;
    @(negedge clk);
  endtask

  task automatic t_abort(input logic [1:0] to_mode, input bit in_str);
    @(negedge clk); mode = 2'b10;
    for (int k = 0; k < 1000; k++) begin
      @(negedge clk);
      if (in_str ? str_wake : ref_wake) break;
    end
    repeat (10) @(negedge clk);
    mode = to_mode;
    @(negedge clk);
    if (to_mode == 2'b01)
      chk({ref_wake, str_wake, ring_hold, str_stress} == 4'b0101, "R9 abort to normal",
          {ref_wake, str_wake, ring_hold, str_stress}, 4'b0101);
    else
      chk({ref_wake, str_wake, ring_hold, str_stress} == 4'b0010, "R9 abort to burn-in",
          {ref_wake, str_wake, ring_hold, str_stress}, 4'b0010);
    chk(!res_valid && ref_count == 0 && stress_count == 0, "R9 cleared",
        int'(ref_count) + res_valid, 0);
    mode = 2'b00;
    @(negedge clk);
  endtask

  initial begin
    #(2_000_000);
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_burn();
    t_normal();
    t_auth(2'b10, 10);
    t_auth(2'b11, 40);
    t_abort(2'b01, 1'b0);
    t_abort(2'b00, 1'b1);
    t_auth(2'b10, 28);
    chk(!lock_bad, "R4 interlock", lock_bad, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule